// File: doc/BRIEF.md
# Error-Corrected Phrase Read Port

This block answers byte and 16-bit word reads from a nonvolatile array that is organised in phrases. Each phrase holds 64 data bits and 8 check bits. Every access fetches the whole phrase that holds the requested bytes. The fetched phrase passes through a single-error-correcting, double-error-detecting decoder, and the block then picks out the byte or word that was asked for. The array sits outside the block and has a combinational read: the block drives a phrase index, and the array returns that phrase's data and check bits in the same cycle.

A requester raises `req` with `addr` and `word`, holds them steady, and drops `req` in the cycle after it sees `rdy`. Bytes and word-aligned words finish in one cycle. A word at an odd address takes two cycles, one fetch for each byte. The two fetches are corrected separately, and their fault results are merged. The command sequencer drives one busy line per array block. A read that targets a busy block waits, and returns no data, until that block is idle. A read of an idle block proceeds normally while another block is busy. Two sticky flags report corrected single faults and uncorrectable double faults. They stay set until `clr` clears them.

Top module: `flash_ecc_rd`

## Requirements
- R1: The phrase index driven on `arr_phrase` is the byte address divided by 8. Byte k of a phrase (k = address mod 8) is data bits [8k+7:8k]. A byte read returns {8'h00, byte}. A word read at address a returns {byte a, byte a+1} in bits [15:8] and [7:0], with a+1 wrapping from the top address to 0.
- R2: The code word occupies positions 0..71. Check bit i (i = 0..6) sits at position 2^i. Check bit 7 is an overall even parity over all 72 bits, at position 0. Data bit j takes the j-th position, counting upwards from 3, that is not a power of two. Any single flipped bit among the 72 is corrected in the returned data, and `sec_flag` is set.
- R3: A phrase with two flipped bits sets `ded_flag`.
- R4: A byte read, or a word read at an even address, raises `rdy` exactly one cycle after the clock edge that accepts the request. `rdy` is a one-cycle pulse.
- R5: A word read at an odd address raises `rdy` two cycles after acceptance. It fetches the phrase of each byte, corrects each phrase separately, and merges the fault results of the two fetches.
- R6: While the block being fetched (phrase index divided by PHRASES_PER_BLOCK) has its `blk_busy` bit set, `rdy` stays low and the read waits. `rdata` is zero whenever `rdy` is low.
- R7: A read of a block whose busy bit is clear completes in its normal cycle count while another block is busy.
- R8: An erased phrase (all 72 bits ones) reads as 8'hFF bytes and raises neither flag.
- R9: `sec_flag` and `ded_flag` stay set until `clr` is high at a clock edge. A fault result produced at that same edge sets its flag anyway.
- R10: If a read has any uncorrectable phrase, it sets only `ded_flag`. A read with corrected faults and no uncorrectable phrase sets only `sec_flag`.
- R11: After reset, `rdy`, `rdata`, `sec_flag` and `ded_flag` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Read request, held until `rdy` |
| word | input | 1 | 1 = 16-bit word read, 0 = byte read |
| addr | input | AW (7) | Byte address |
| blk_busy | input | NUM_BLOCKS (2) | Per-block busy from the command sequencer |
| clr | input | 1 | Clears both sticky fault flags |
| arr_phrase | output | PIW (4) | Phrase index presented to the array |
| arr_data | input | 64 | Phrase data bits from the array |
| arr_chk | input | 8 | Phrase check bits from the array |
| rdy | output | 1 | Read complete, `rdata` valid |
| rdata | output | 16 | Read result |
| sec_flag | output | 1 | Sticky corrected-single-fault flag |
| ded_flag | output | 1 | Sticky uncorrectable-fault flag |

## Verification
A decoder that computes a wrong syndrome shows up on the very read that uses it. The returned byte differs from the clean value, or a flag rises on a clean or erased phrase, at the `rdy` of that access. If the state that carries the first byte of an odd-address word is lost or miscaptured, the error appears in the high byte, or in a missing fault merge, at the second-cycle `rdy`. A state machine that ignores a busy block, or that restarts on a held request, breaks the one- and two-cycle `rdy` timing, and this is visible within a few cycles of the request.

// File: rtl/flash_rd_pkg.sv
package flash_rd_pkg;
  localparam int PH_BYTES = 8;
  localparam int DATA_W   = 64;
  localparam int CHK_W    = 8;
  localparam int SYN_W    = 7;
  localparam int CODE_W   = DATA_W + CHK_W;

  typedef enum logic {ST_IDLE, ST_SECOND} rd_state_e;

  // code-word position of data bit j: j-th non-power-of-two position from 3
  function automatic int data_pos(input int j);
    int k;
    int res;
    k = 0;
    res = 0;
    for (int p = 1; p < CODE_W; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (k == j) res = p;
        k++;
      end
    end
    return res;
  endfunction
endpackage

// File: rtl/flash_rd_rstsync.sv
module flash_rd_rstsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/flash_rd_secded.sv
module flash_rd_secded
  import flash_rd_pkg::*;
(
  input  logic [DATA_W-1:0] data_i,
  input  logic [CHK_W-1:0]  chk_i,
  output logic [DATA_W-1:0] data_o,
  output logic              corr_o,
  output logic              unc_o
);
  logic [CODE_W-1:0] cw;
  logic [CODE_W-1:0] fixed;
  logic [SYN_W-1:0]  syn;
  logic              par;
  logic              syn_ok;

  assign cw[0] = chk_i[CHK_W-1];
  for (genvar i = 0; i < SYN_W; i++) begin : g_chk
    assign cw[1 << i] = chk_i[i];
  end
  for (genvar j = 0; j < DATA_W; j++) begin : g_dat
    assign cw[data_pos(j)] = data_i[j];
    assign data_o[j]       = fixed[data_pos(j)];
  end

  always_comb begin
    syn = '0;
    for (int p = 1; p < CODE_W; p++) begin
      if (cw[p]) syn = syn ^ SYN_W'(p);
    end
  end

  assign par    = ^cw;
  assign syn_ok = (32'(syn) < CODE_W);

  always_comb begin
    fixed = cw;
    if (par && syn_ok) begin
      for (int p = 1; p < CODE_W; p++) begin
        if (SYN_W'(p) == syn) fixed[p] = ~cw[p];
      end
    end
  end

  assign unc_o  = (!par && (syn != '0)) || (par && !syn_ok);
  assign corr_o = par && syn_ok;
endmodule

// File: rtl/flash_rd_lane.sv
module flash_rd_lane
  import flash_rd_pkg::*;
(
  input  logic [DATA_W-1:0] phrase_i,
  input  logic [2:0]        ofs_i,
  output logic [7:0]        hi_o,
  output logic [7:0]        lo_o
);
  logic [7:0] lane [PH_BYTES];

  for (genvar k = 0; k < PH_BYTES; k++) begin : g_lane
    assign lane[k] = phrase_i[8*k +: 8];
  end

  assign hi_o = lane[ofs_i];
  assign lo_o = lane[ofs_i | 3'd1];
endmodule

// File: rtl/flash_ecc_rd.sv
module flash_ecc_rd
  import flash_rd_pkg::*;
#(
  parameter int NUM_BLOCKS        = 2,
  parameter int PHRASES_PER_BLOCK = 8,
  localparam int PIW   = $clog2(NUM_BLOCKS * PHRASES_PER_BLOCK),
  localparam int AW    = PIW + 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req,
  input  logic                  word,
  input  logic [AW-1:0]         addr,
  input  logic [NUM_BLOCKS-1:0] blk_busy,
  input  logic                  clr,
  output logic [PIW-1:0]        arr_phrase,
  input  logic [DATA_W-1:0]     arr_data,
  input  logic [CHK_W-1:0]      arr_chk,
  output logic                  rdy,
  output logic [15:0]           rdata,
  output logic                  sec_flag,
  output logic                  ded_flag
);
  localparam int PPB_W = $clog2(PHRASES_PER_BLOCK);
  localparam int BLK_W = PIW - PPB_W;

  logic            rst_i_n;
  rd_state_e       st_q, st_n;
  logic [7:0]      hi_q, hi_n;
  logic            pc_q, pc_n, pu_q, pu_n;
  logic            ld_first;
  logic            rdy_q, rdy_n;
  logic [15:0]     rdata_q, rdata_n;
  logic            sec_q, sec_n, ded_q, ded_n;
  logic            done, f_cor, f_unc;
  logic [AW-1:0]   cur_addr;
  logic [BLK_W-1:0] blk;
  logic            busy;
  logic [DATA_W-1:0] fixed;
  logic            corr, unc;
  logic [7:0]      b_hi, b_lo;

  flash_rd_rstsync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n));

  assign cur_addr   = (st_q == ST_SECOND) ? addr + AW'(1) : addr;
  assign arr_phrase = cur_addr[AW-1:3];
  assign blk        = arr_phrase[PIW-1:PPB_W];
  assign busy       = blk_busy[blk];

  flash_rd_secded u_dec (
    .data_i(arr_data), .chk_i(arr_chk),
    .data_o(fixed), .corr_o(corr), .unc_o(unc)
  );

  flash_rd_lane u_lane (
    .phrase_i(fixed), .ofs_i(cur_addr[2:0]),
    .hi_o(b_hi), .lo_o(b_lo)
  );

  // next-state
  always_comb begin
    st_n     = st_q;
    ld_first = 1'b0;
    done     = 1'b0;
    f_cor    = 1'b0;
    f_unc    = 1'b0;
    rdata_n  = '0;
    unique case (st_q)
      ST_IDLE: begin
        if (req && !rdy_q && !busy) begin
          if (word && addr[0]) begin
            st_n     = ST_SECOND;
            ld_first = 1'b1;
          end else begin
            done    = 1'b1;
            f_cor   = corr;
            f_unc   = unc;
            rdata_n = word ? {b_hi, b_lo} : {8'h00, b_hi};
          end
        end
      end
      ST_SECOND: begin
        if (!busy) begin
          st_n    = ST_IDLE;
          done    = 1'b1;
          f_cor   = pc_q | corr;
          f_unc   = pu_q | unc;
          rdata_n = {hi_q, b_hi};
        end
      end
      default: st_n = ST_IDLE;
    endcase
    hi_n  = ld_first ? b_hi : hi_q;
    pc_n  = ld_first ? corr : pc_q;
    pu_n  = ld_first ? unc  : pu_q;
    rdy_n = done;
    sec_n = (sec_q & ~clr) | (done & f_cor & ~f_unc);
    ded_n = (ded_q & ~clr) | (done & f_unc);
  end

  // registers
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      st_q    <= ST_IDLE;
      rdy_q   <= 1'b0;
      rdata_q <= '0;
      sec_q   <= 1'b0;
      ded_q   <= 1'b0;
    end else begin
      st_q    <= st_n;
      rdy_q   <= rdy_n;
      rdata_q <= rdata_n;
      sec_q   <= sec_n;
      ded_q   <= ded_n;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      hi_q <= '0;
      pc_q <= 1'b0;
      pu_q <= 1'b0;
    end else if (ld_first) begin
      hi_q <= hi_n;
      pc_q <= pc_n;
      pu_q <= pu_n;
    end
  end

  assign rdy      = rdy_q;
  assign rdata    = rdata_q;
  assign sec_flag = sec_q;
  assign ded_flag = ded_q;
endmodule

// File: rtl/flash_ecc_rd_chk.sv
module flash_ecc_rd_chk #(
  parameter int NUM_BLOCKS        = 2,
  parameter int PHRASES_PER_BLOCK = 8,
  localparam int PIW   = $clog2(NUM_BLOCKS * PHRASES_PER_BLOCK),
  localparam int PPB_W = $clog2(PHRASES_PER_BLOCK)
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [NUM_BLOCKS-1:0] blk_busy,
  input logic                  clr,
  input logic [PIW-1:0]        arr_phrase,
  input logic                  rdy,
  input logic [15:0]           rdata,
  input logic                  sec_flag,
  input logic                  ded_flag
);
  logic [PIW-PPB_W-1:0] cblk;
  assign cblk = arr_phrase[PIW-1:PPB_W];

  // R6
  busy_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blk_busy[cblk] |=> !rdy);

  // R6
  rdata_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rdy |-> rdata == 16'h0000);

  // R4
  rdy_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rdy |=> !rdy);

  // R9
  sec_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sec_flag && !clr |=> sec_flag);

  // R9
  ded_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ded_flag && !clr |=> ded_flag);

  // R9
  clr_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!sec_flag && !ded_flag) || rdy);

  // R10
  flag_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !($rose(sec_flag) && $rose(ded_flag)));
endmodule

bind flash_ecc_rd flash_ecc_rd_chk #(
  .NUM_BLOCKS(NUM_BLOCKS), .PHRASES_PER_BLOCK(PHRASES_PER_BLOCK)
) u_chk (
  .clk(clk), .rst_n(rst_n), .blk_busy(blk_busy), .clr(clr),
  .arr_phrase(arr_phrase), .rdy(rdy), .rdata(rdata),
  .sec_flag(sec_flag), .ded_flag(ded_flag)
);

// File: tb/flash_ecc_rd_tb.sv
module flash_ecc_rd_tb;
  localparam int NB = 2, PPB = 8, NPH = NB * PPB, PIW = 4, AW = 7, NBYTES = NPH * 8;

  logic clk = 1'b0;
  logic rst_n, req, word, clr;
  logic [AW-1:0] addr;
  logic [NB-1:0] blk_busy;
  logic [PIW-1:0] arr_phrase;
  logic [63:0] arr_data;
  logic [7:0] arr_chk;
  logic rdy, sec_flag, ded_flag;
  logic [15:0] rdata;
  int vectors = 0, miscompares = 0, ticks = 0;

  always #5 clk = ~clk;

  flash_ecc_rd u_dut (
    .clk(clk), .rst_n(rst_n), .req(req), .word(word), .addr(addr),
    .blk_busy(blk_busy), .clr(clr), .arr_phrase(arr_phrase),
    .arr_data(arr_data), .arr_chk(arr_chk), .rdy(rdy), .rdata(rdata),
    .sec_flag(sec_flag), .ded_flag(ded_flag)
  );

  // array model: clean content, erased phrases when g%8==7
  function automatic logic [63:0] clean(input int g);
    if (g % 8 == 7) return '1;
    return (64'h9E37_79B9_7F4A_7C15 * 64'(g + 1)) ^ {8{8'(g * 17)}};
  endfunction

  // encoder per R2
  function automatic logic [7:0] enc(input logic [63:0] d);
    logic [7:0] c;
    int k;
    c = '0;
    k = 0;
    for (int p = 1; p < 72; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (d[k]) for (int i = 0; i < 7; i++) if (p[i]) c[i] = ~c[i];
        k++;
      end
    end
    c[7] = (^d) ^ (^c[6:0]);
    return c;
  endfunction

  function automatic logic [63:0] fd(input int g);
    logic [63:0] m;
    m = '0;
    case (g % 8)
      1: m[(g * 5) % 64] = 1'b1;
      3: begin m[3] = 1'b1; m[40] = 1'b1; end
      5: m[17] = 1'b1;
      6: m[63] = 1'b1;
      default: ;
    endcase
    return m;
  endfunction

  function automatic logic [7:0] fc(input int g);
    if (g % 8 == 2) return 8'h04;
    if (g % 8 == 5) return 8'h80;
    return 8'h00;
  endfunction

  // 0 clean, 1 single, 2 double
  function automatic int kind(input int g);
    case (g % 8)
      1, 2, 6: return 1;
      3, 5:    return 2;
      default: return 0;
    endcase
  endfunction

  function automatic logic [7:0] ebyte(input int a);
    logic [63:0] d;
    d = clean((a % NBYTES) / 8);
    return d[(a % 8) * 8 +: 8];
  endfunction

  assign arr_data = clean(int'(arr_phrase)) ^ fd(int'(arr_phrase));
  assign arr_chk  = ((int'(arr_phrase) % 8 == 7) ? 8'hFF : enc(clean(int'(arr_phrase)))) ^ fc(int'(arr_phrase));

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input int a, input bit w, input bit clr_first,
                    output int cyc, output logic [15:0] d, output logic s, output logic dd);
    if (clr_first) begin clr = 1'b1; @(negedge clk); clr = 1'b0; end
    req = 1'b1; addr = AW'(a); word = w; cyc = 0;
    do begin @(negedge clk); cyc++; end while (!rdy && cyc < 40);
    d = rdata; s = sec_flag; dd = ded_flag;
    req = 1'b0; word = 1'b0;
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    ticks++;
    if (ticks > 150000) begin
      miscompares++;
      $display("FAIL watchdog act=%0d exp<150000", ticks);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    int cyc, g1, g2, k1, k2, ecy;
    logic [15:0] d, ed;
    logic s, dd, es, edd;
    rst_n = 1'b0; req = 1'b0; word = 1'b0; clr = 1'b0; addr = '0; blk_busy = '0;
    repeat (3) @(negedge clk);
    // R11 reset state
    check(rdy == 1'b0 && rdata == 16'h0 && sec_flag == 1'b0 && ded_flag == 1'b0,
          "R11 reset", {rdy, sec_flag, ded_flag, rdata}, 32'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // sweep: R1 R2 R3 R4 R5 R8 R10
    for (int w = 0; w < 2; w++) begin
      for (int a = 0; a < NBYTES; a++) begin
        rd(a, w[0], 1'b1, cyc, d, s, dd);
        g1 = a / 8;
        g2 = ((a + 1) % NBYTES) / 8;
        k1 = kind(g1);
        k2 = (w == 1 && a % 2 == 1) ? kind(g2) : 0;
        ecy = (w == 1 && a % 2 == 1) ? 2 : 1;
        ed = (w == 1) ? {ebyte(a), ebyte(a + 1)} : {8'h00, ebyte(a)};
        edd = (k1 == 2 || k2 == 2 || (w == 1 && a % 2 == 0 && k1 == 2));
        es = !edd && (k1 == 1 || k2 == 1);
        check(cyc == ecy, ecy == 2 ? "R5 cycles" : "R4 cycles", cyc, ecy);
        if (!edd) check(d == ed, (k1 == 0 && k2 == 0) ? "R1 data" : "R2 corrected data", d, ed);
        check(s == es && dd == edd, edd ? "R3/R10 flags" : "R2/R8 flags", {s, dd}, {es, edd});
      end
    end

    // R9 stickiness across a clean read, then clear
    rd(8, 1'b0, 1'b1, cyc, d, s, dd);
    rd(0, 1'b0, 1'b0, cyc, d, s, dd);
    check(s == 1'b1 && dd == 1'b0, "R9 sticky", {s, dd}, 2'b10);
    clr = 1'b1; @(negedge clk); clr = 1'b0;
    check(sec_flag == 1'b0 && ded_flag == 1'b0, "R9 clear", {sec_flag, ded_flag}, 2'b00);

    // R6 stall on busy block 0
    blk_busy = 2'b01; req = 1'b1; addr = AW'(5); word = 1'b0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check(rdy == 1'b0 && rdata == 16'h0, "R6 stall", {rdy, rdata}, 32'h0);
    end
    blk_busy = 2'b00;
    @(negedge clk);
    check(rdy == 1'b1 && rdata == {8'h00, ebyte(5)}, "R6 release", {rdy, rdata}, {1'b1, 8'h00, ebyte(5)});
    req = 1'b0; @(negedge clk);

    // R7 idle block proceeds while block 0 busy
    blk_busy = 2'b01;
    rd(70, 1'b0, 1'b0, cyc, d, s, dd);
    check(cyc == 1 && d == {8'h00, ebyte(70)}, "R7 other block", {cyc[15:0], d}, {16'd1, 8'h00, ebyte(70)});
    blk_busy = 2'b00;

    // R5/R6 odd word across blocks, second block busy
    blk_busy = 2'b10; req = 1'b1; addr = AW'(63); word = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(rdy == 1'b0 && rdata == 16'h0, "R6 second-half stall", {rdy, rdata}, 32'h0);
    end
    blk_busy = 2'b00;
    @(negedge clk);
    check(rdy == 1'b1 && rdata == {ebyte(63), ebyte(64)}, "R5 cross-block word",
          {rdy, rdata}, {1'b1, ebyte(63), ebyte(64)});
    req = 1'b0; word = 1'b0; @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule